// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is the countdown timer of a per-processor local interrupt controller. Software programs a 32-bit start value, a divider setting and a timer entry through a small register port. The entry holds an interrupt vector, a mask flag and a choice between one-shot and periodic operation. The base clock passes through a power-of-two prescaler, and each prescaled tick lowers the current count by one. When the count runs out, the block raises a request for one cycle. The request carries the programmed vector and is marked as edge-triggered.

The 3-bit divider code is not a contiguous field: its two low bits come from register bits 1:0 and its top bit from register bit 3. The prescaler shift is the code plus one, wrapped to three bits, so code 7 divides by one. Writing the start value reloads the count and restarts the prescaler. The first decrement therefore lands exactly one divided period after the write.

The register port selects one of four words: start value (0), current count (1, read-only), divider (2) and timer entry (3). Reads are combinational from the select lines.

Top module: `lct_timer`

## Requirements
- R1: After reset, start value, current count and divider read 0, the timer entry reads 0x0001_0000 (masked), and no request is raised.
- R2: A divider write keeps only bits 0, 1 and 3 (mask 0xB); every other bit reads back 0.
- R3: The divider code is {reg[3], reg[1:0]}. The shift is (code+1) mod 8, and the count steps once every 2^shift base cycles, so code 7 steps every cycle and code 0 every 2 cycles.
- R4: Writing the start value sets the current count to that value on the next cycle and restarts the prescaler. The first decrement happens 2^shift cycles after the write edge, and an earlier run is abandoned.
- R5: In one-shot mode (entry bit 17 = 0), the count falls by one per tick and stays at 0. Exactly one request appears, (N+1)*2^shift cycles after a write of start value N.
- R6: In periodic mode (entry bit 17 = 1), the count runs N down to 0 and reloads N. A request appears every (N+1)*2^shift cycles, including N = 0.
- R7: The timer entry keeps vector bits [7:0], mask bit 16 and periodic bit 17; all other bits read 0.
- R8: While mask bit 16 is set, no request is raised, but counting continues. A one-shot expiry that falls while masked is lost and does not fire after unmasking.
- R9: A request is irq_valid high for one cycle per expiry, with irq_vector equal to the entry vector and irq_level = 0 (edge).
- R10: A one-shot start value of 0 reads back 0 and never raises a request.
- R11: Writes to the current-count select change neither the count nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 start, 1 current, 2 divider, 3 entry |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried by the request |
| irq_level | output | 1 | Trigger mode of the request, 0 = edge |

## Verification
The bound checker watches the count on every cycle. It confirms that the count moves only on a tick or a load, steps down by exactly one, reloads the start value at the periodic wrap and holds at zero in one-shot mode. It also confirms that every request follows a tick, is unmasked, and carries the vector programmed in the cycle before. The prescaler period, the absolute cycle of each expiry, the single firing of a one-shot run, the loss of a masked expiry and the register bit masks are end-to-end timing and readback facts, so only the bench's sweeps show them. Those sweeps cover every divider code and several start values in both modes, and compare the count against a computed value on every cycle.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int SHIFT_W  = 3;
  localparam int PRE_W    = (1 << SHIFT_W) - 1;
  localparam int DATA_W   = 32;
  localparam int VEC_W    = 8;
  localparam int MASK_POS = 16;
  localparam int PER_POS  = 17;
  localparam logic [3:0] DIV_KEEP = 4'hB;

  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_CURR = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_VEC  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } vec_entry_t;

  // Gather the scattered divider code: reg bit 3 is code bit 2.
  function automatic logic [SHIFT_W-1:0] div_code(input logic [3:0] r);
    return {r[3], r[1:0]};
  endfunction

  // Shift grows with the code and wraps, so the top code means divide by one.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [SHIFT_W-1:0] c);
    return c + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/lct_regs.sv
module lct_regs
  import lct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_count,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  init_cnt,
  output vec_entry_t        entry,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [SHIFT_W-1:0] shift
);
  logic [3:0] div_reg;
  reg_sel_e   sel;

  assign sel      = reg_sel_e'(addr);
  assign load_stb = wr && (sel == SEL_INIT);
  assign load_val = wdata[CNT_W-1:0];
  assign shift    = div_shift(div_code(div_reg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt       <= '0;
      div_reg        <= '0;
      entry.vector   <= '0;
      entry.masked   <= 1'b1;
      entry.periodic <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_INIT: init_cnt <= load_val;
        SEL_DIV:  div_reg  <= wdata[3:0] & DIV_KEEP;
        SEL_VEC: begin
          entry.vector   <= wdata[VEC_W-1:0];
          entry.masked   <= wdata[MASK_POS];
          entry.periodic <= wdata[PER_POS];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_INIT: rdata = DATA_W'(init_cnt);
      SEL_CURR: rdata = DATA_W'(cur_count);
      SEL_DIV:  rdata = DATA_W'(div_reg);
      SEL_VEC: begin
        rdata[VEC_W-1:0] = entry.vector;
        rdata[MASK_POS]  = entry.masked;
        rdata[PER_POS]   = entry.periodic;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler
  import lct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] low_mask;

  // Low-bit mask of width "shift"; a tick fires when those bits are all ones.
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign low_mask[i] = (i < int'(shift));
  end

  assign tick = &(pre_cnt | ~low_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (restart) pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + PRE_W'(1);
  end
endmodule

// File: rtl/lct_counter.sv
module lct_counter
  import lct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_cnt,
  input  logic             tick,
  input  vec_entry_t       entry,
  output logic [CNT_W-1:0] cur,
  output logic             expire,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic armed;
  logic step;
  logic at_zero;

  assign step    = tick && !load;
  assign at_zero = (cur == '0);
  assign expire  = step && at_zero && (entry.periodic || armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cur   <= load_val;
      armed <= |load_val;
    end else if (step) begin
      if (!at_zero) begin
        cur <= cur - CNT_W'(1);
      end else begin
        if (entry.periodic) cur <= init_cnt;
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= expire && !entry.masked;
      if (expire && !entry.masked) irq_vector <= entry.vector;
    end
  end
endmodule

// File: rtl/lct_timer.sv
module lct_timer
  import lct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_valid,
  output logic [7:0]  irq_vector,
  output logic        irq_level
);
  logic [CNT_W-1:0]   init_cnt;
  logic [CNT_W-1:0]   cur;
  logic [CNT_W-1:0]   load_val;
  logic               load;
  logic               tick;
  logic               expire;
  logic [SHIFT_W-1:0] shift;
  vec_entry_t         entry;
  logic               periodic;
  logic               masked;
  logic [VEC_W-1:0]   vector;

  assign periodic  = entry.periodic;
  assign masked    = entry.masked;
  assign vector    = entry.vector;
  assign irq_level = 1'b0;

  lct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cur_count(cur), .rdata(reg_rdata),
    .init_cnt(init_cnt), .entry(entry), .load_stb(load),
    .load_val(load_val), .shift(shift)
  );

  lct_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load), .shift(shift), .tick(tick)
  );

  lct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .init_cnt(init_cnt), .tick(tick), .entry(entry), .cur(cur),
    .expire(expire), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/lct_timer_checker.sv
module lct_timer_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] init_cnt,
  input logic             periodic,
  input logic             masked,
  input logic [7:0]       vector,
  input logic             irq_valid,
  input logic [7:0]       irq_vector
);
  a_r4_load_sets_count: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val)));

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur));

  a_r5_step_down_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur != '0) |=> (cur == $past(cur) - CNT_W'(1)));

  a_r5_oneshot_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur == '0 && !periodic) |=> (cur == '0));

  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur == '0 && periodic) |=> (cur == $past(init_cnt)));

  a_r8_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(masked));

  a_r9_vector_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(vector)));

  a_r9_irq_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($past(tick) && !$past(load)));
endmodule

bind lct_timer lct_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(load_val),
  .cur(cur), .init_cnt(init_cnt), .periodic(periodic), .masked(masked),
  .vector(vector), .irq_valid(irq_valid), .irq_vector(irq_vector)
);

// File: tb/lct_timer_bench.sv
module lct_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic        irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lct_timer u_lct_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1; d = reg_rdata;
    reg_addr = 2'd1;
  endtask

  function automatic int shift_of(input int code);
    return (code == 7) ? 0 : code + 1;
  endfunction

  // Program one run and compare count and request on every cycle.
  task automatic run(input int code, input int n, input bit per, input logic [7:0] vec);
    int s, p, t;
    longint exp_cur;
    bit exp_irq;
    s = shift_of(code);
    p = (n + 1) << s;
    wr(2'd3, {14'd0, per, 1'b0, 8'd0, vec});
    wr(2'd2, {28'd0, code[2], 1'b0, code[1:0]});
    wr(2'd0, n);
    for (int k = 1; k <= (per ? 4 * p + 3 : 2 * p + 8); k++) begin
      @(posedge clk); #1;
      t = k >> s;
      if (per) begin
        exp_cur = n - (t % (n + 1));
        exp_irq = (k % p) == 0;
      end else begin
        exp_cur = (t >= n) ? 0 : n - t;
        exp_irq = (n != 0) && (k == p);
      end
      // R3 R4 R5 R6 R10: count follows the prescaled timeline
      check(reg_rdata == exp_cur, per ? "R6 periodic count" : "R5 one-shot count", reg_rdata, exp_cur);
      // R5 R6 R9 R10: request timing
      check(irq_valid == exp_irq, per ? "R6 periodic expiry" : "R5/R10 one-shot expiry", irq_valid, exp_irq);
      if (irq_valid && exp_irq) begin
        check(irq_vector == vec, "R9 vector", irq_vector, vec);
        check(irq_level == 1'b0, "R9 edge trigger", irq_level, 0);
      end
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, d); check(d == 0, "R1 start value", d, 0);
    rd(2'd1, d); check(d == 0, "R1 current count", d, 0);
    rd(2'd2, d); check(d == 0, "R1 divider", d, 0);
    rd(2'd3, d); check(d == 32'h0001_0000, "R1 entry masked", d, 32'h0001_0000);
    check(irq_valid == 1'b0, "R1 no request", irq_valid, 0);
    // R2 divider bits
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check(d == 32'hB, "R2 divider keep", d, 32'hB);
    wr(2'd2, 32'h0000_0004); rd(2'd2, d); check(d == 0, "R2 divider bit2 dropped", d, 0);
    // R7 entry fields
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); check(d == 32'h0003_00FF, "R7 entry fields", d, 32'h0003_00FF);
    // R4 abandon a running timer, then sweep R3/R5/R10 over every divider code
    wr(2'd3, 32'h0000_0010); wr(2'd2, 32'hB); wr(2'd0, 100);
    repeat (3) @(posedge clk);
    for (int c = 0; c < 8; c++)
      for (int n = 0; n < 4; n++)
        run(c, n, 1'b0, 8'(8'h20 + c * 4 + n));
    // R6 periodic sweep
    for (int ci = 0; ci < 3; ci++)
      for (int n = 0; n < 5; n++)
        run((ci == 0) ? 7 : ci - 1, n, 1'b1, 8'(8'h80 + ci * 8 + n));
    // R8 masked: counting continues, lost expiry
    wr(2'd3, 32'h0001_0042); wr(2'd2, 32'hB); wr(2'd0, 2);
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk); #1;
      check(irq_valid == 1'b0, "R8 masked no request", irq_valid, 0);
      check(reg_rdata == ((k >= 2) ? 0 : 2 - k), "R8 counts while masked", reg_rdata, (k >= 2) ? 0 : 2 - k);
    end
    wr(2'd3, 32'h0000_0042);
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk); #1;
      check(irq_valid == 1'b0, "R8 lost expiry stays lost", irq_valid, 0);
    end
    // R11 current-count writes ignored
    wr(2'd1, 32'h55);
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); #1;
      check(reg_rdata == 0, "R11 count unchanged", reg_rdata, 0);
      check(irq_valid == 1'b0, "R11 no restart", irq_valid, 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule